// File: doc/BRIEF.md
# Dual-Loop Digital Lock Detector

This block watches the phase comparisons of two synthesizer loops, all timed on one oscillator clock. In each loop a reference strobe and a divided-VCO strobe arrive roughly together. The block measures how many oscillator cycles separate them and treats the pair as a good comparison when that gap is small. Each loop keeps a count of consecutive good comparisons. The loop counts as locked once that run is long enough.

A shared lock line reports the status of both loops together. It is modelled as an open-drain pin: an output enable that pulls the line low, with a data value that is always low. The line is pulled low only when every powered loop is locked. A loop whose enable is low is left out of the judgement. With both loops off, the line is released.

Top module: `dual_lock_monitor`

## Requirements
- R1: After reset, every loop's run count is zero and `lock_oe` is 0 (line released).
- R2: A comparison is good when the second strobe of a pair arrives 0, 1 or 2 oscillator cycles after the first. The strobes may come in either order, and a reference strobe and a divided strobe in the same cycle give an offset of 0.
- R3: If the second strobe has not arrived within 2 cycles after the first (offset of 3 or more), the comparison is bad. A bad comparison zeroes that loop's run count and clears its lock flag on the same clock edge.
- R4: A loop becomes locked on the edge that completes its 15th consecutive good comparison. After 14 it is still unlocked.
- R5: The run count saturates at 15, so a loop stays locked for as long as good comparisons continue.
- R6: `lock_oe` is 1 only when at least one loop is enabled and every enabled loop is locked. It is 0 when any enabled loop is unlocked.
- R7: Strobes on a disabled loop are ignored, and the line is judged on the enabled loop alone.
- R8: With both loop enables low, `lock_oe` is 0.
- R9: A disabled loop's comparison state and run count are cleared. On re-enable it needs 15 fresh good comparisons before it counts as locked.
- R10: `lock_dat` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; all timing is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_en | input | NLOOP | Per-loop power enable (bit 0 = loop 0) |
| ref_pulse | input | NLOOP | Per-loop reference strobe, one cycle wide |
| div_pulse | input | NLOOP | Per-loop divided-VCO strobe, one cycle wide |
| lock_oe | output | 1 | 1 = pull the shared lock line low (all enabled loops locked) |
| lock_dat | output | 1 | Data value of the lock line, tied low |

## Verification
Two events can fall on the same clock edge: one loop completes its 15th good comparison while the other loop times out on a bad one. The bench first locks both loops. It then starts a pair on each loop at the same time, giving loop 0 a gap of 2 and loop 1 a gap of 5, so the good result and the timeout land on one edge. The line must come out released, because the loop that just failed outranks the one that is still locked. The bench also toggles a loop's enable in the middle of a run and checks that the shared line follows the remaining loop at once.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
    typedef enum logic [1:0] {
        MS_IDLE     = 2'd0,
        MS_HAVE_REF = 2'd1,
        MS_HAVE_DIV = 2'd2
    } meter_state_t;
endpackage

// File: rtl/loop_phase_meter.sv
module loop_phase_meter
    import lockdet_pkg::*;
#(
    parameter int WIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ref_stb,
    input  logic div_stb,
    output logic cmp_good,
    output logic cmp_bad
);
    localparam int CW = $clog2(WIN + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(WIN - 1);

    meter_state_t st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= MS_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state and comparison outputs
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        cmp_good = 1'b0;
        cmp_bad  = 1'b0;
        if (!en) begin
            st_d  = MS_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                MS_IDLE: begin
                    if (ref_stb && div_stb) begin
                        cmp_good = 1'b1;
                    end else if (ref_stb) begin
                        st_d  = MS_HAVE_REF;
                        cnt_d = CW'(1);
                    end else if (div_stb) begin
                        st_d  = MS_HAVE_DIV;
                        cnt_d = CW'(1);
                    end
                end
                MS_HAVE_REF: begin
                    if (div_stb) begin
                        cmp_good = 1'b1;
                        st_d     = MS_IDLE;
                    end else if (cnt_q == CNT_LAST) begin
                        cmp_bad = 1'b1;
                        st_d    = MS_IDLE;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                MS_HAVE_DIV: begin
                    if (ref_stb) begin
                        cmp_good = 1'b1;
                        st_d     = MS_IDLE;
                    end else if (cnt_q == CNT_LAST) begin
                        cmp_bad = 1'b1;
                        st_d    = MS_IDLE;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                default: st_d = MS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lock_run_counter.sv
module lock_run_counter #(
    parameter int LOCK_RUN = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cmp_good,
    input  logic cmp_bad,
    output logic locked
);
    localparam int RW = $clog2(LOCK_RUN + 1);
    localparam logic [RW-1:0] RUN_MAX  = RW'(LOCK_RUN);
    localparam logic [RW-1:0] RUN_NEAR = RW'(LOCK_RUN - 1);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            run_q  <= '0;
            locked <= 1'b0;
        end else if (cmp_bad) begin
            run_q  <= '0;
            locked <= 1'b0;
        end else if (cmp_good) begin
            if (run_q != RUN_MAX) run_q <= run_q + RW'(1);
            locked <= (run_q >= RUN_NEAR);
        end
    end
endmodule

// File: rtl/lock_combine.sv
module lock_combine #(
    parameter int NLOOP = 2
) (
    input  logic [NLOOP-1:0] loop_en,
    input  logic [NLOOP-1:0] locked,
    output logic             pull_low
);
    always_comb begin
        pull_low = (|loop_en) && (&(locked | ~loop_en));
    end
endmodule

// File: rtl/dual_lock_monitor.sv
module dual_lock_monitor #(
    parameter int NLOOP    = 2,
    parameter int WIN      = 3,
    parameter int LOCK_RUN = 15
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic [NLOOP-1:0] loop_en,
    input  logic [NLOOP-1:0] ref_pulse,
    input  logic [NLOOP-1:0] div_pulse,
    output logic             lock_oe,
    output logic             lock_dat
);
    logic [NLOOP-1:0] good_ev;
    logic [NLOOP-1:0] bad_ev;
    logic [NLOOP-1:0] loop_locked;

    for (genvar g = 0; g < NLOOP; g++) begin : g_loop
        loop_phase_meter #(.WIN(WIN)) u_meter (
            .clk      (osc_clk),
            .rst_n    (rst_n),
            .en       (loop_en[g]),
            .ref_stb  (ref_pulse[g]),
            .div_stb  (div_pulse[g]),
            .cmp_good (good_ev[g]),
            .cmp_bad  (bad_ev[g])
        );
        lock_run_counter #(.LOCK_RUN(LOCK_RUN)) u_run (
            .clk      (osc_clk),
            .rst_n    (rst_n),
            .en       (loop_en[g]),
            .cmp_good (good_ev[g]),
            .cmp_bad  (bad_ev[g]),
            .locked   (loop_locked[g])
        );
    end

    lock_combine #(.NLOOP(NLOOP)) u_comb (
        .loop_en  (loop_en),
        .locked   (loop_locked),
        .pull_low (lock_oe)
    );

    assign lock_dat = 1'b0;
endmodule

// File: rtl/dual_lock_checker.sv
module dual_lock_checker #(
    parameter int NLOOP = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NLOOP-1:0] loop_en,
    input logic             lock_oe,
    input logic             lock_dat,
    input logic [NLOOP-1:0] good_ev,
    input logic [NLOOP-1:0] bad_ev,
    input logic [NLOOP-1:0] locked
);
    always_comb begin
        a_r10_data_low: assert (lock_dat == 1'b0);
    end

    a_r8_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en == '0) |-> !lock_oe);

    a_r6_drive_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        lock_oe |-> ((locked | ~loop_en) == '1));

    for (genvar g = 0; g < NLOOP; g++) begin : g_chk
        a_r2_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({good_ev[g], bad_ev[g]}));

        a_r3_bad_clears: assert property (@(posedge clk) disable iff (!rst_n)
            bad_ev[g] |=> !locked[g]);

        a_r4_lock_on_good: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(locked[g]) |-> $past(good_ev[g]));

        a_r9_off_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
            !loop_en[g] |=> !locked[g]);
    end
endmodule

bind dual_lock_monitor dual_lock_checker #(.NLOOP(NLOOP)) u_chk (
    .clk     (osc_clk),
    .rst_n   (rst_n),
    .loop_en (loop_en),
    .lock_oe (lock_oe),
    .lock_dat(lock_dat),
    .good_ev (good_ev),
    .bad_ev  (bad_ev),
    .locked  (loop_locked)
);

// File: tb/dual_lock_monitor_bench.sv
`timescale 1ns/1ps
module dual_lock_monitor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] en = 2'b00;
    logic [1:0] rp = 2'b00;
    logic [1:0] dp = 2'b00;
    logic       lock_oe, lock_dat;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    dual_lock_monitor u_dual_lock_monitor (
        .osc_clk  (clk),
        .rst_n    (rst_n),
        .loop_en  (en),
        .ref_pulse(rp),
        .div_pulse(dp),
        .lock_oe  (lock_oe),
        .lock_dat (lock_dat)
    );

    task automatic check(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // one pair per loop, both starting together; d = gap of the second strobe
    task automatic pair2(int d0, int d1, bit div_first);
        int last = (d0 > d1 ? d0 : d1) + 4;
        for (int t = 0; t <= last; t++) begin
            @(negedge clk);
            rp[0] = div_first ? (t == d0) : (t == 0);
            dp[0] = div_first ? (t == 0)  : (t == d0);
            rp[1] = div_first ? (t == d1) : (t == 0);
            dp[1] = div_first ? (t == 0)  : (t == d1);
        end
        @(negedge clk);
        rp = 2'b00;
        dp = 2'b00;
    endtask

    task automatic pairs(int n, int d0, int d1, bit df);
        for (int k = 0; k < n; k++) pair2(d0, d1, df);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 released after reset", lock_oe, 1'b0);
        check("R10 data low", lock_dat, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_single_lock();
        en = 2'b01;
        pairs(14, 1, 9, 1'b0);
        check("R4 not locked after 14", lock_oe, 1'b0);
        pair2(2, 9, 1'b0);
        check("R4 R2 locked after 15th (gap 2)", lock_oe, 1'b1);
        pairs(10, 0, 9, 1'b1);
        check("R5 held through further goods (gap 0)", lock_oe, 1'b1);
        pairs(20, 2, 9, 1'b1);
        check("R2 div-first gap 2 keeps lock", lock_oe, 1'b1);
    endtask

    task automatic t_bad_clears();
        // gap 3, ref first: bad at edge t0+2
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            rp[0] = (t == 0);
        end
        @(negedge clk);
        rp = 2'b00;
        check("R3 bad clears lock immediately", lock_oe, 1'b0);
        repeat (6) @(negedge clk);
        pairs(14, 1, 9, 1'b0);
        pair2(3, 9, 1'b1);
        check("R3 div-first gap 3 resets run", lock_oe, 1'b0);
        pairs(14, 1, 9, 1'b0);
        check("R3 run restarted from zero", lock_oe, 1'b0);
        pair2(1, 9, 1'b0);
        check("R4 relocked after 15 fresh", lock_oe, 1'b1);
    endtask

    task automatic t_both_loops();
        en = 2'b11;
        @(negedge clk);
        check("R6 R9 fresh loop 1 unlocked releases line", lock_oe, 1'b0);
        pairs(14, 1, 1, 1'b0);
        check("R6 loop 1 at 14 keeps line released", lock_oe, 1'b0);
        pair2(0, 2, 1'b1);
        check("R6 both locked drives low", lock_oe, 1'b1);
        // same-edge: loop 0 good at gap 2, loop 1 bad timeout on that edge
        pair2(2, 5, 1'b0);
        check("R6 R3 same-edge good and bad releases line", lock_oe, 1'b0);
        pairs(15, 1, 1, 1'b0);
        check("R6 both relocked", lock_oe, 1'b1);
    endtask

    task automatic t_enables();
        pairs(3, 1, 8, 1'b0);
        check("R6 loop 1 bad releases line", lock_oe, 1'b0);
        en = 2'b01;
        @(negedge clk);
        check("R7 disabled loop 1 ignored", lock_oe, 1'b1);
        pairs(4, 1, 7, 1'b0);
        check("R7 strobes on disabled loop ignored", lock_oe, 1'b1);
        en = 2'b00;
        @(negedge clk);
        check("R8 none enabled releases", lock_oe, 1'b0);
        pairs(15, 1, 1, 1'b0);
        check("R8 strobes while all off keep line released", lock_oe, 1'b0);
        en = 2'b10;
        @(negedge clk);
        check("R9 re-enabled loop 1 starts unlocked", lock_oe, 1'b0);
        pairs(14, 9, 1, 1'b0);
        check("R9 needs 15 fresh goods", lock_oe, 1'b0);
        pair2(9, 1, 1'b0);
        check("R7 judged on loop 1 alone", lock_oe, 1'b1);
        check("R10 data low at end", lock_dat, 1'b0);
    endtask

    initial begin
        t_reset();
        t_single_lock();
        t_bad_clears();
        t_both_loops();
        t_enables();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule